// File: doc/BRIEF.md
# Transceiver-to-Fabric Rate Adaptation Bridge

This block joins the coding-layer logic of a serial transceiver, clocked at the full rate, to general-purpose fabric logic clocked at half that rate. On the receive side it collects two successive narrow words and presents them together as one word of twice the width. The fabric therefore moves the same bandwidth at half the clock rate. On the transmit side it takes one wide word from the fabric and sends its two halves out one after the other.

Three static configuration inputs change how the block runs. The first can remove the width change altogether. The second picks the clock handed to the fabric: either the recovered receive clock or the transmit PLL clock. The third chooses whether that clock passes through a divide-by-two stage. Control requests raised by the fast side can last a single cycle. The bridge stretches each one so that the slower fabric clock always captures it.

All datapath registers run on the fast coding-layer clock. A single phase flag, cleared by reset, sets the boundaries of the wide words. A companion wide-word valid flag shows the fabric when a complete pair is present.

Top module: `xcvr_fabric_bridge`

## Requirements
- R1: While reset is active, and on the first clock after it, the wide receive bus, its valid flag, the narrow transmit bus and every stretched control output are all zero.
- R2: With bypass off, each wide receive word holds the earlier of two successive narrow words in bits [NARROW_W-1:0] and the later word in bits [2*NARROW_W-1:NARROW_W].
- R3: With bypass off, the wide valid flag is high on every second fast cycle, never on two cycles in a row, and it marks the cycle in which a complete pair is presented.
- R4: With bypass off, the narrow transmit output first carries bits [NARROW_W-1:0] of the wide word sampled on a low-phase cycle (valid low). On the next cycle (valid high) it carries bits [2*NARROW_W-1:NARROW_W] of that same word.
- R5: With bypass on, every fast cycle sets the wide valid flag. The received narrow word appears in the low half and the upper half is all zeros.
- R6: With bypass on, each fast cycle places bits [NARROW_W-1:0] of the current wide transmit word on the narrow output, and the upper half is ignored.
- R7: A one-cycle request on a control line holds the matching stretched output high for exactly STRETCH_LEN (default 2) fast cycles, starting one cycle after the request.
- R8: A request that arrives while a line is already being held restarts the hold from the full length.
- R9: Configuration bit cfg_clk_sel_i chooses the source of the fabric clock: 0 gives the recovered clock and 1 gives the PLL clock.
- R10: With cfg_clk_div_i at 1, the fabric clock toggles once on each rising edge of the selected source, which halves its rate. With cfg_clk_div_i at 0, the fabric clock is the selected source itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast coding-layer clock for the datapath |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| clk_rec_i | input | 1 | Recovered receive clock, one of the fabric clock sources |
| clk_pll_i | input | 1 | Transmit PLL clock, the other fabric clock source |
| cfg_bypass_i | input | 1 | Static: 1 removes the width change |
| cfg_clk_sel_i | input | 1 | Static: fabric clock source, 0 recovered, 1 PLL |
| cfg_clk_div_i | input | 1 | Static: 1 divides the fabric clock by two |
| rx_data_i | input | NARROW_W | Narrow receive word, one per fast cycle |
| rx_wide_o | output | 2*NARROW_W | Wide receive word toward the fabric |
| rx_wide_vld_o | output | 1 | Wide receive word is complete this cycle |
| tx_wide_i | input | 2*NARROW_W | Wide transmit word from the fabric |
| tx_data_o | output | NARROW_W | Narrow transmit word, one per fast cycle |
| ctrl_req_i | input | CTRL_W | Control requests from the fast side, possibly one cycle long |
| ctrl_hold_o | output | CTRL_W | Stretched control lines toward the fabric |
| fab_clk_o | output | 1 | Clock handed to the fabric |

## Verification
The properties treat the configuration bits as static inside any window they examine. They also assume that the transmit wide word is valid on every cycle, because the bridge itself decides which cycle consumes it. To respect this, the stimulus changes the bypass bit only on a falling clock edge and only between test phases. It then judges each later sample from the valid flag instead of from a cycle count. The stretch properties are written as an exact equivalence with the last two request samples, so the stimulus drives requests as isolated or closely spaced single-cycle pulses.

// File: rtl/xfb_pkg.sv
package xfb_pkg;
  typedef enum logic {
    FCLK_FROM_REC = 1'b0,
    FCLK_FROM_PLL = 1'b1
  } fclk_src_e;

  typedef enum logic {
    HALF_LOW  = 1'b0,
    HALF_HIGH = 1'b1
  } half_e;
endpackage

// File: rtl/xfb_rx_demux.sv
module xfb_rx_demux #(
  parameter int unsigned NARROW_W = 10,
  localparam int unsigned WIDE_W = 2 * NARROW_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bypass_i,
  input  xfb_pkg::half_e      half_i,
  input  logic [NARROW_W-1:0] data_i,
  output logic [WIDE_W-1:0]   wide_o,
  output logic                vld_o
);
  import xfb_pkg::*;

  logic [NARROW_W-1:0] low_q, low_d;
  logic [WIDE_W-1:0]   wide_q, wide_d;
  logic                vld_q, vld_d;
  logic                low_en, wide_en;

  // next-state
  always_comb begin
    low_en  = 1'b0;
    wide_en = 1'b0;
    low_d   = low_q;
    wide_d  = wide_q;
    vld_d   = 1'b0;
    if (bypass_i) begin
      wide_en = 1'b1;
      wide_d  = {{NARROW_W{1'b0}}, data_i};
      vld_d   = 1'b1;
    end else if (half_i == HALF_LOW) begin
      low_en = 1'b1;
      low_d  = data_i;
    end else begin
      wide_en = 1'b1;
      wide_d  = {data_i, low_q};
      vld_d   = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q  <= '0;
      wide_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (low_en)  low_q  <= low_d;
      if (wide_en) wide_q <= wide_d;
      vld_q <= vld_d;
    end
  end

  assign wide_o = wide_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/xfb_tx_mux.sv
module xfb_tx_mux #(
  parameter int unsigned NARROW_W = 10,
  localparam int unsigned WIDE_W = 2 * NARROW_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bypass_i,
  input  xfb_pkg::half_e      half_i,
  input  logic [WIDE_W-1:0]   wide_i,
  output logic [NARROW_W-1:0] data_o
);
  import xfb_pkg::*;

  logic [NARROW_W-1:0] high_q, high_d;
  logic [NARROW_W-1:0] out_q, out_d;
  logic                high_en;

  // next-state
  always_comb begin
    high_en = 1'b0;
    high_d  = high_q;
    out_d   = wide_i[NARROW_W-1:0];
    if (!bypass_i) begin
      if (half_i == HALF_LOW) begin
        high_en = 1'b1;
        high_d  = wide_i[WIDE_W-1:NARROW_W];
      end else begin
        out_d = high_q;
      end
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      high_q <= '0;
      out_q  <= '0;
    end else begin
      if (high_en) high_q <= high_d;
      out_q <= out_d;
    end
  end

  assign data_o = out_q;
endmodule

// File: rtl/xfb_ctrl_stretch.sv
module xfb_ctrl_stretch #(
  parameter int unsigned STRETCH_LEN = 2,
  localparam int unsigned CNT_W = $clog2(STRETCH_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic hold_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // next-state: a request reloads the full length, otherwise count down
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (req_i) begin
      cnt_en = 1'b1;
      cnt_d  = CNT_W'(STRETCH_LEN);
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign hold_o = (cnt_q != '0);
endmodule

// File: rtl/xfb_fabclk_gen.sv
module xfb_fabclk_gen (
  input  logic rst_ni,
  input  logic clk_rec_i,
  input  logic clk_pll_i,
  input  logic sel_i,
  input  logic div_i,
  output logic fab_clk_o
);
  import xfb_pkg::*;

  fclk_src_e src;
  logic      src_clk;
  logic      div_q, div_d;

  assign src     = fclk_src_e'(sel_i);
  assign src_clk = (src == FCLK_FROM_PLL) ? clk_pll_i : clk_rec_i;

  // next-state
  always_comb begin
    div_d = ~div_q;
  end

  // register: toggles once per rising edge of the chosen source
  always_ff @(posedge src_clk or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= 1'b0;
    end else begin
      div_q <= div_d;
    end
  end

  assign fab_clk_o = div_i ? div_q : src_clk;
endmodule

// File: rtl/xcvr_fabric_bridge.sv
module xcvr_fabric_bridge #(
  parameter int unsigned NARROW_W    = 10,
  parameter int unsigned CTRL_W      = 4,
  parameter int unsigned STRETCH_LEN = 2,
  localparam int unsigned WIDE_W     = 2 * NARROW_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clk_rec_i,
  input  logic                clk_pll_i,
  input  logic                cfg_bypass_i,
  input  logic                cfg_clk_sel_i,
  input  logic                cfg_clk_div_i,
  input  logic [NARROW_W-1:0] rx_data_i,
  output logic [WIDE_W-1:0]   rx_wide_o,
  output logic                rx_wide_vld_o,
  input  logic [WIDE_W-1:0]   tx_wide_i,
  output logic [NARROW_W-1:0] tx_data_o,
  input  logic [CTRL_W-1:0]   ctrl_req_i,
  output logic [CTRL_W-1:0]   ctrl_hold_o,
  output logic                fab_clk_o
);
  import xfb_pkg::*;

  // reset: asserted asynchronously, released on the fast clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // half-select flag shared by both directions
  half_e half_q, half_d;
  always_comb begin
    if (cfg_bypass_i) half_d = HALF_LOW;
    else              half_d = (half_q == HALF_LOW) ? HALF_HIGH : HALF_LOW;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) half_q <= HALF_LOW;
    else             half_q <= half_d;
  end

  xfb_rx_demux #(.NARROW_W(NARROW_W)) rx_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .bypass_i (cfg_bypass_i),
    .half_i   (half_q),
    .data_i   (rx_data_i),
    .wide_o   (rx_wide_o),
    .vld_o    (rx_wide_vld_o)
  );

  xfb_tx_mux #(.NARROW_W(NARROW_W)) tx_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .bypass_i (cfg_bypass_i),
    .half_i   (half_q),
    .wide_i   (tx_wide_i),
    .data_o   (tx_data_o)
  );

  for (genvar g = 0; g < CTRL_W; g++) begin : g_stretch
    xfb_ctrl_stretch #(.STRETCH_LEN(STRETCH_LEN)) st_i (
      .clk_i  (clk_i),
      .rst_ni (rst_sync_n),
      .req_i  (ctrl_req_i[g]),
      .hold_o (ctrl_hold_o[g])
    );
  end

  xfb_fabclk_gen clkgen_i (
    .rst_ni    (rst_ni),
    .clk_rec_i (clk_rec_i),
    .clk_pll_i (clk_pll_i),
    .sel_i     (cfg_clk_sel_i),
    .div_i     (cfg_clk_div_i),
    .fab_clk_o (fab_clk_o)
  );
endmodule

// File: rtl/xfb_checker.sv
module xfb_checker #(
  parameter int unsigned N  = 10,
  parameter int unsigned CW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_bypass,
  input logic [N-1:0]   rx_data,
  input logic [2*N-1:0] rx_wide,
  input logic           rx_vld,
  input logic [2*N-1:0] tx_wide,
  input logic [N-1:0]   tx_data,
  input logic [CW-1:0]  ctrl_req,
  input logic [CW-1:0]  ctrl_hold
);
  // cycles seen since reset release, saturating at 3
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  // R3: no two valid cycles in a row outside bypass
  assert_vld_alternate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd1 && rx_vld && !cfg_bypass && !$past(cfg_bypass)) |=> !rx_vld);

  // R2: a wide word pairs the last two narrow samples, earlier one low
  assert_rx_pairing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && rx_vld && !$past(cfg_bypass))
      |-> rx_wide == {$past(rx_data), $past(rx_data, 2)});

  // R4: high half follows the low half of the same wide word
  assert_tx_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && rx_vld && !$past(cfg_bypass))
      |-> tx_data == $past(tx_wide[2*N-1:N], 2));

  // R5: bypass gives a valid word with a zero upper half every cycle
  assert_bypass_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bypass |=> (rx_vld && rx_wide[2*N-1:N] == '0 && rx_wide[N-1:0] == $past(rx_data)));

  // R6: bypass forwards the low half of the wide transmit word
  assert_bypass_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bypass |=> tx_data == $past(tx_wide[N-1:0]));

  // R7 / R8: stretched line equals a request in either of the last two cycles
  for (genvar g = 0; g < CW; g++) begin : g_hold
    assert_hold_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2) |-> ctrl_hold[g] == ($past(ctrl_req[g]) || $past(ctrl_req[g], 2)));
    assert_hold_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd1 && ctrl_req[g]) |=> ##1 ctrl_hold[g]);
  end
endmodule

bind xcvr_fabric_bridge xfb_checker #(.N(NARROW_W), .CW(CTRL_W)) chk_i (
  .clk        (clk_i),
  .rst_n      (rst_sync_n),
  .cfg_bypass (cfg_bypass_i),
  .rx_data    (rx_data_i),
  .rx_wide    (rx_wide_o),
  .rx_vld     (rx_wide_vld_o),
  .tx_wide    (tx_wide_i),
  .tx_data    (tx_data_o),
  .ctrl_req   (ctrl_req_i),
  .ctrl_hold  (ctrl_hold_o)
);

// File: tb/xcvr_fabric_bridge_tb_top.sv
module xcvr_fabric_bridge_tb_top;
  localparam int unsigned N  = 10;
  localparam int unsigned CW = 4;
  localparam int unsigned NV = 8;
  localparam logic [N-1:0] RX_TAB [NV] = '{10'h001, 10'h3FF, 10'h155, 10'h2AA,
                                            10'h0F0, 10'h30C, 10'h123, 10'h200};

  logic clk = 1'b0;
  logic clk_pll = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_bypass = 1'b0, cfg_sel = 1'b0, cfg_div = 1'b0;
  logic [N-1:0]   rx_data = '0;
  logic [2*N-1:0] tx_wide = '0;
  logic [CW-1:0]  ctrl_req = '0;
  logic [2*N-1:0] rx_wide;
  logic           rx_vld;
  logic [N-1:0]   tx_data;
  logic [CW-1:0]  ctrl_hold;
  logic           fab_clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always #8 clk_pll = ~clk_pll;

  xcvr_fabric_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clk_rec_i(clk), .clk_pll_i(clk_pll),
    .cfg_bypass_i(cfg_bypass), .cfg_clk_sel_i(cfg_sel), .cfg_clk_div_i(cfg_div),
    .rx_data_i(rx_data), .rx_wide_o(rx_wide), .rx_wide_vld_o(rx_vld),
    .tx_wide_i(tx_wide), .tx_data_o(tx_data),
    .ctrl_req_i(ctrl_req), .ctrl_hold_o(ctrl_hold), .fab_clk_o(fab_clk)
  );

  function automatic logic [2*N-1:0] tx_of(input logic [N-1:0] d);
    return {d ^ 10'h2AA, d ^ 10'h155};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0]   prev_d;
    logic [2*N-1:0] prev_w;
    logic           prev_v;
    int             nvld;

    // R1: reset state
    tx_wide = tx_of(10'h3C3);
    rx_data = 10'h3C3;
    ctrl_req = '1;
    repeat (3) step();
    check(rx_wide == '0 && !rx_vld, "R1 rx", {rx_vld, rx_wide}, 0);
    check(tx_data == '0 && ctrl_hold == '0, "R1 tx/ctrl", {ctrl_hold, tx_data}, 0);
    ctrl_req = '0;
    rx_data = '0;
    tx_wide = '0;
    rst_n = 1'b1;
    step();
    check(rx_wide == '0 && !rx_vld && tx_data == '0 && ctrl_hold == '0,
          "R1 first cycle", {ctrl_hold, tx_data, rx_vld}, 0);
    repeat (4) step();

    // table walk, width change active: R2 R3 R4
    prev_d = rx_data;
    prev_w = tx_wide;
    prev_v = rx_vld;
    nvld = 0;
    for (int k = 0; k < NV; k++) begin
      rx_data = RX_TAB[k];
      tx_wide = tx_of(RX_TAB[k]);
      step();
      check(rx_vld != prev_v, "R3 alternate", rx_vld, !prev_v);
      if (rx_vld) begin
        nvld++;
        check(rx_wide == {RX_TAB[k], prev_d}, "R2 pair", rx_wide, {RX_TAB[k], prev_d});
        check(tx_data == prev_w[2*N-1:N], "R4 high", tx_data, prev_w[2*N-1:N]);
      end else begin
        check(tx_data == tx_wide[N-1:0], "R4 low", tx_data, tx_wide[N-1:0]);
      end
      prev_d = RX_TAB[k];
      prev_w = tx_wide;
      prev_v = rx_vld;
    end
    check(nvld == NV / 2, "R3 count", nvld, NV / 2);

    // table walk, bypass: R5 R6
    cfg_bypass = 1'b1;
    for (int k = 0; k < NV; k++) begin
      rx_data = RX_TAB[NV-1-k];
      tx_wide = tx_of(RX_TAB[NV-1-k]);
      step();
      check(rx_vld && rx_wide == {{N{1'b0}}, rx_data}, "R5 bypass rx",
            {rx_vld, rx_wide}, {1'b1, {N{1'b0}}, rx_data});
      check(tx_data == tx_wide[N-1:0], "R6 bypass tx", tx_data, tx_wide[N-1:0]);
    end
    cfg_bypass = 1'b0;
    rx_data = 10'h0AB;
    step();
    check(!rx_vld, "R3 leaving bypass starts low half", rx_vld, 0);

    // R7: single request held exactly two cycles
    ctrl_req = 4'b0001;
    step();
    ctrl_req = '0;
    check(ctrl_hold == 4'b0001, "R7 cycle1", ctrl_hold, 4'b0001);
    step();
    check(ctrl_hold == 4'b0001, "R7 cycle2", ctrl_hold, 4'b0001);
    step();
    check(ctrl_hold == 4'b0000, "R7 released", ctrl_hold, 0);

    // R8: second request during the hold restarts it
    ctrl_req = 4'b1000;
    step();
    ctrl_req = '0;
    step();
    ctrl_req = 4'b1000;
    step();
    ctrl_req = '0;
    check(ctrl_hold == 4'b1000, "R8 after restart", ctrl_hold, 4'b1000);
    step();
    check(ctrl_hold == 4'b1000, "R8 extended", ctrl_hold, 4'b1000);
    step();
    check(ctrl_hold == 4'b0000, "R8 released", ctrl_hold, 0);

    // R9 R10: fabric clock selection and division
    cfg_sel = 1'b0;
    cfg_div = 1'b0;
    @(posedge clk); #1;
    check(fab_clk == 1'b1, "R9 rec high", fab_clk, 1);
    @(negedge clk); #1;
    check(fab_clk == 1'b0, "R9 rec low", fab_clk, 0);
    cfg_div = 1'b1;
    @(posedge clk); #1;
    prev_v = fab_clk;
    @(posedge clk); #1;
    check(fab_clk != prev_v, "R10 rec divided", fab_clk, !prev_v);
    @(negedge clk); #1;
    check(fab_clk != prev_v, "R10 holds between edges", fab_clk, !prev_v);
    cfg_sel = 1'b1;
    cfg_div = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      check(fab_clk == clk_pll, "R9 pll follows", fab_clk, clk_pll);
    end
    cfg_div = 1'b1;
    @(posedge clk_pll); #1;
    prev_v = fab_clk;
    @(posedge clk_pll); #1;
    check(fab_clk != prev_v, "R10 pll divided", fab_clk, !prev_v);
    @(posedge clk); #1;
    check(fab_clk != prev_v, "R10 pll holds", fab_clk, !prev_v);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule